// File: doc/BRIEF.md
# Boot ROM Overlay and Expansion Bank Router

This block chooses which memory answers each CPU access to the lower 32 KB window of the address space. The candidates are a boot ROM overlay, main RAM, or one of sixteen 32 KB expansion RAM banks. Reads and writes are routed separately. While the overlay is on, reads come from the ROM and writes still go into main RAM underneath it. Boot code can therefore copy itself into RAM and then switch the ROM away.

The CPU controls the routing through three I/O ports. Port select 0 is an 8-bit bank register that can be read and written. Port select 1 is a write-only strobe that turns the overlay on. Port select 2 is a write-only strobe that turns the overlay off. Port select 3 is unused. Bit 4 of the bank register picks the mode. When it is set, the block is in normal mode and the overlay flag decides the routing. When it is clear, the bank named by bits 3:0 serves both reads and writes. The memories, full port decoding and ROM image loading are outside the block.

Top module: `ovl_bank_ctrl`

## Requirements
- R1: After a synchronous reset, the bank register holds 0x78 and the overlay is on. Read source is therefore ROM (code 0) and write source is main RAM (code 1).
- R2: A write with io_sel=0 stores all 8 data bits in the bank register, including the unused bits 7:5. bank_rdata returns the stored value.
- R3: With bank register bit 4 set and the overlay on, rd_src is ROM (0) and wr_src is main RAM (1).
- R4: With bank register bit 4 set and the overlay off, rd_src and wr_src are both main RAM (1).
- R5: With bank register bit 4 clear, rd_src and wr_src are both expansion bank (code 2). bank_num equals bank register bits 3:0, so all 16 banks can be reached.
- R6: A write with io_sel=1 turns the overlay on. A write with io_sel=2 turns it off. The data value of either write has no effect on the bank register or the routing.
- R7: Turning the overlay on or off while bit 4 is clear leaves rd_src and wr_src unchanged. The stored flag takes effect once bit 4 is set again.
- R8: A new routing appears in the cycle after the clock edge that takes the write. The state does not change when io_wr is low, or when io_sel=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Single-cycle I/O write strobe |
| io_sel | input | 2 | Port select: 0 bank register, 1 overlay on, 2 overlay off, 3 none |
| io_wdata | input | 8 | I/O write data |
| bank_rdata | output | 8 | Bank register read-back |
| rd_src | output | 2 | Read source: 0 ROM, 1 main RAM, 2 expansion bank |
| wr_src | output | 2 | Write source: 0 ROM, 1 main RAM, 2 expansion bank |
| bank_num | output | 4 | Selected expansion bank |

## Verification
The bench builds the block with its default parameters: an 8-bit bank register, a 4-bit bank field and mode bit 4. With these values every one of the sixteen banks and all three routing sources can be reached with directed I/O writes. Small arrays stand in for the ROM, the main RAM and the banks, and the bench moves data through the selects. This shows that writes land in RAM below the ROM overlay, and that each bank keeps its own contents.

// File: rtl/ovl_bank_pkg.sv
package ovl_bank_pkg;
  typedef enum logic [1:0] {
    SRC_ROM  = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_BANK = 2'd2
  } src_t;

  typedef enum logic [1:0] {
    PORT_BANK = 2'd0,
    PORT_ROM  = 2'd1,
    PORT_RAM  = 2'd2,
    PORT_NONE = 2'd3
  } port_t;
endpackage

// File: rtl/ovl_bank_reg.sv
module ovl_bank_reg #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h78
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RESET_VAL;
    else if (wr_en) q <= wdata;
  end

  a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q == RESET_VAL));
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> $stable(q));
  a_r2_store_all_bits: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (q == $past(wdata)));
endmodule

// File: rtl/ovl_overlay_flag.sv
module ovl_overlay_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_on,
  input  logic set_off,
  output logic on
);
  always_ff @(posedge clk) begin
    if (rst)          on <= 1'b1;
    else if (set_on)  on <= 1'b1;
    else if (set_off) on <= 1'b0;
  end

  a_r6_on_strobe: assert property (@(posedge clk) disable iff (rst)
    set_on |=> on);
  a_r6_off_strobe: assert property (@(posedge clk) disable iff (rst)
    (set_off && !set_on) |=> !on);
endmodule

// File: rtl/ovl_route.sv
module ovl_route
  import ovl_bank_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             normal_mode,
  input  logic             overlay_on,
  input  logic [SEL_W-1:0] sel_field,
  output src_t             rd_src,
  output src_t             wr_src,
  output logic [SEL_W-1:0] bank_num
);
  always_comb begin
    if (!normal_mode) begin
      rd_src = SRC_BANK;
      wr_src = SRC_BANK;
    end else begin
      rd_src = overlay_on ? SRC_ROM : SRC_MAIN;
      wr_src = SRC_MAIN;
    end
    bank_num = sel_field;
  end
endmodule

// File: rtl/ovl_bank_ctrl.sv
module ovl_bank_ctrl
  import ovl_bank_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 4,
  parameter int MODE_BIT = 4,
  parameter logic [DATA_W-1:0] RESET_BANK = 8'h78
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [1:0]        io_sel,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] bank_rdata,
  output logic [1:0]        rd_src,
  output logic [1:0]        wr_src,
  output logic [SEL_W-1:0]  bank_num
);
  logic bank_we, ovl_on_we, ovl_off_we, overlay_q;
  logic [DATA_W-1:0] bank_q;
  src_t rd_s, wr_s;

  assign bank_we    = io_wr && (port_t'(io_sel) == PORT_BANK);
  assign ovl_on_we  = io_wr && (port_t'(io_sel) == PORT_ROM);
  assign ovl_off_we = io_wr && (port_t'(io_sel) == PORT_RAM);

  ovl_bank_reg #(.DATA_W(DATA_W), .RESET_VAL(RESET_BANK)) u_bank (
    .clk(clk), .rst(rst), .wr_en(bank_we), .wdata(io_wdata), .q(bank_q)
  );

  ovl_overlay_flag u_flag (
    .clk(clk), .rst(rst), .set_on(ovl_on_we), .set_off(ovl_off_we), .on(overlay_q)
  );

  ovl_route #(.SEL_W(SEL_W)) u_route (
    .normal_mode(bank_q[MODE_BIT]), .overlay_on(overlay_q),
    .sel_field(bank_q[SEL_W-1:0]),
    .rd_src(rd_s), .wr_src(wr_s), .bank_num(bank_num)
  );

  assign bank_rdata = bank_q;
  assign rd_src     = rd_s;
  assign wr_src     = wr_s;

  a_r5_bank_both_paths: assert property (@(posedge clk) disable iff (rst)
    !bank_q[MODE_BIT] |-> (rd_src == 2'd2 && wr_src == 2'd2));
  a_r3_writes_under_rom: assert property (@(posedge clk) disable iff (rst)
    (bank_q[MODE_BIT] && overlay_q) |-> (rd_src == 2'd0 && wr_src == 2'd1));
  a_r4_all_main: assert property (@(posedge clk) disable iff (rst)
    (bank_q[MODE_BIT] && !overlay_q) |-> (rd_src == 2'd1 && wr_src == 2'd1));
  a_r6_strobe_keeps_bank: assert property (@(posedge clk) disable iff (rst)
    (ovl_on_we || ovl_off_we) |=> $stable(bank_rdata));
  a_r7_flag_hidden_in_bank: assert property (@(posedge clk) disable iff (rst)
    (!bank_q[MODE_BIT] && !bank_we) |=> ($stable(rd_src) && $stable(wr_src)));
endmodule

// File: tb/ovl_bank_ctrl_test.sv
`timescale 1ns/1ps
module ovl_bank_ctrl_test;
  logic clk = 0, rst = 1, io_wr = 0;
  logic [1:0] io_sel = 2'd3;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] bank_rdata;
  logic [1:0] rd_src, wr_src;
  logic [3:0] bank_num;
  int checks = 0, fails = 0;

  logic [7:0] rom_m [16];
  logic [7:0] main_m [16];
  logic [7:0] bank_m [16][16];

  always #4 clk = ~clk;

  ovl_bank_ctrl uut (.clk(clk), .rst(rst), .io_wr(io_wr), .io_sel(io_sel),
    .io_wdata(io_wdata), .bank_rdata(bank_rdata), .rd_src(rd_src),
    .wr_src(wr_src), .bank_num(bank_num));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [1:0] sel, logic [7:0] d);
    @(negedge clk); io_wr = 1; io_sel = sel; io_wdata = d;
    @(negedge clk); io_wr = 0; io_sel = 2'd3; #1;
  endtask

  task automatic mem_write(int a, logic [7:0] d);
    case (wr_src)
      2'd1: main_m[a] = d;
      2'd2: bank_m[bank_num][a] = d;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] mem_read(int a);
    case (rd_src)
      2'd0: return rom_m[a];
      2'd1: return main_m[a];
      default: return bank_m[bank_num][a];
    endcase
  endfunction

  task automatic t_reset;
    chk("R1 bank reg", bank_rdata, 8'h78);
    chk("R1 rd_src", rd_src, 0);
    chk("R1 wr_src", wr_src, 1);
  endtask

  task automatic t_overlay_shadow;
    mem_write(3, 8'hC3);
    chk("R3 read shadowed by rom", mem_read(3), 8'hA3);
    io_write(2'd2, 8'h00);
    chk("R4 rd_src main", rd_src, 1);
    chk("R4 wr_src main", wr_src, 1);
    chk("R4 data landed in main", mem_read(3), 8'hC3);
    io_write(2'd1, 8'h55);
    chk("R6 overlay on rd", rd_src, 0);
    chk("R6 data ignored", bank_rdata, 8'h78);
    io_write(2'd2, 8'hEF);
    chk("R6 overlay off rd", rd_src, 1);
    chk("R6 off data ignored", bank_rdata, 8'h78);
  endtask

  task automatic t_banks;
    for (int b = 0; b < 16; b++) begin
      io_write(2'd0, 8'(b));
      chk("R5 rd_src bank", rd_src, 2);
      chk("R5 wr_src bank", wr_src, 2);
      chk("R5 bank_num", bank_num, b);
      mem_write(5, 8'(8'h40 + b));
    end
    for (int b = 0; b < 16; b++) begin
      io_write(2'd0, 8'(b));
      chk("R5 bank keeps own data", mem_read(5), 8'h40 + b);
    end
  endtask

  task automatic t_readback;
    io_write(2'd0, 8'hE9);
    chk("R2 all bits kept", bank_rdata, 8'hE9);
    chk("R5 bank mode e9", rd_src, 2);
    io_write(2'd0, 8'h1F);
    chk("R2 readback 1f", bank_rdata, 8'h1F);
  endtask

  task automatic t_hidden_flag;
    io_write(2'd0, 8'h03);
    io_write(2'd1, 8'h00);
    chk("R7 rd stays bank", rd_src, 2);
    chk("R7 wr stays bank", wr_src, 2);
    io_write(2'd0, 8'h10);
    chk("R7 flag on after exit", rd_src, 0);
    io_write(2'd0, 8'h02);
    io_write(2'd2, 8'h00);
    chk("R7 rd stays bank off", rd_src, 2);
    io_write(2'd0, 8'hF0);
    chk("R7 flag off after exit", rd_src, 1);
  endtask

  task automatic t_timing_and_ignore;
    @(negedge clk); io_wr = 1; io_sel = 2'd1; io_wdata = 8'h00;
    #1 chk("R8 not before edge", rd_src, 1);
    @(negedge clk); io_wr = 0; io_sel = 2'd3; #1;
    chk("R8 after edge", rd_src, 0);
    @(negedge clk); io_wr = 0; io_sel = 2'd0; io_wdata = 8'h05;
    @(negedge clk); io_sel = 2'd2; @(negedge clk); io_sel = 2'd3; #1;
    chk("R8 no strobe bank", bank_rdata, 8'hF0);
    chk("R8 no strobe flag", rd_src, 0);
    io_write(2'd3, 8'h00);
    chk("R8 port 3 bank", bank_rdata, 8'hF0);
    chk("R8 port 3 flag", rd_src, 0);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; #1;
    t_reset();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      rom_m[i] = 8'(8'hA0 + i); main_m[i] = 8'h00;
      for (int j = 0; j < 16; j++) bank_m[i][j] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst = 0; #1;
    t_reset();
    t_overlay_shadow();
    t_banks();
    t_readback();
    t_hidden_flag();
    t_timing_and_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule